// File: doc/BRIEF.md
# Global Histogram Range Finder

This block watches a raw pixel stream and builds a histogram of every value it receives during the active part of a frame. When the vertical blank begins, it steps through the histogram once, one bin per clock, and keeps a running sum of the bin counts. The sweep stops raising the lower bound once that sum passes a programmed count of low outliers. The upper bound is found the same way against the frame's total pixel count minus a programmed count of high outliers. The pixels discarded at both ends are treated as defective sensor elements.

The two bounds are taken into the range registers when the sweep ends. During the next frame, each valid pixel is compared against those registers. One clock after the pixel arrives, the block reports a flag that tells later contrast stages whether to use the pixel or skip it. Each bin is cleared as the sweep reads it, so the histogram is empty when the next frame starts.

The vertical blank must last at least 2^PIX_W + 1 clocks so that the sweep can finish.

Top module: `pixel_range_finder`

## Requirements
- R1: After reset, range_lo is 0, range_hi is 2^PIX_W-1 and flag_valid is 0, so every pixel of the first frame is flagged in range.
- R2: A pixel enters the histogram and the frame total only when pix_valid is 1, vblank is 0 and no sweep is running. Pixels with pix_valid low, pixels during vblank and pixels during a sweep change neither the bounds nor flag_valid.
- R3: A rising edge of vblank starts one sweep. The sweep reads bins 0 to 2^PIX_W-1 in ascending order, one per clock, and loads the range registers on the edge that processes the last bin.
- R4: The new range_lo is the smallest value v for which the count of pixels with value at most v is greater than discard_lo. If no such v exists, range_lo is 2^PIX_W-1.
- R5: The new range_hi is the smallest value v for which the count of pixels with value at most v is at least total minus discard_hi. If discard_hi is at least the total, the target is 0 and range_hi is 0.
- R6: The sweep clears each bin after reading it, so the bounds of a frame depend only on that frame's pixels.
- R7: frame_start restarts the frame total. A valid pixel that arrives in the same cycle is counted as the first pixel.
- R8: One clock after an accepted pixel, flag_valid is 1 and in_range is 1 exactly when range_lo <= pixel <= range_hi. The comparison uses the registers as they stood when the pixel arrived, which are the bounds from the previous frame.
- R9: The range registers hold their value from the start of a sweep until the sweep's final bin. Each bin and the frame total are CNT_W bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel data qualifier |
| pix_data | input | PIX_W | Raw pixel value |
| frame_start | input | 1 | First pixel of a frame; restarts the frame total |
| vblank | input | 1 | Vertical blank; a rising edge starts the sweep |
| discard_lo | input | CNT_W | Number of pixels to drop at the bottom of the histogram |
| discard_hi | input | CNT_W | Number of pixels to drop at the top of the histogram |
| range_lo | output | PIX_W | Lower bound in use for the current frame |
| range_hi | output | PIX_W | Upper bound in use for the current frame |
| flag_valid | output | 1 | in_range is valid this cycle |
| in_range | output | 1 | Previous pixel lies within [range_lo, range_hi] |

## Verification
The hardest cases are the degenerate bounds: a frame with no pixels, and discard counts at or above the frame total. In both cases the low search never succeeds and the high target falls to zero, so the lower bound ends up above the upper one. The stimulus builds these cases on purpose:
- an empty frame;
- a frame whose discard counts exceed its pixel count;
- a frame of one repeated value, followed by a frame that probes the single-value window on both sides.

Junk valid pixels are also driven during each blank, so that a sweep which read or counted them would shift the next bounds.

// File: rtl/rf_pkg.sv
package rf_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } sweep_phase_e;
endpackage

// File: rtl/rf_hist_bank.sv
module rf_hist_bank #(
    parameter int PIX_W = 8,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [PIX_W-1:0] inc_idx,
    input  logic             clr_en,
    input  logic [PIX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt
);
    localparam int NBINS = 1 << PIX_W;

    logic [CNT_W-1:0] bins_q [NBINS];

    for (genvar g = 0; g < NBINS; g++) begin : g_bin
        logic [CNT_W-1:0] bin_d;
        always_comb begin
            bin_d = bins_q[g];
            if (clr_en && rd_idx == PIX_W'(g)) begin
                bin_d = '0;
            end else if (inc_en && inc_idx == PIX_W'(g)) begin
                bin_d = bins_q[g] + CNT_W'(1);
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) bins_q[g] <= '0;
            else        bins_q[g] <= bin_d;
        end
    end

    assign rd_cnt = bins_q[rd_idx];

    // R2
    inc_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_en && clr_en));

    // R6
    bin_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> bins_q[$past(rd_idx)] == '0);
endmodule

// File: rtl/rf_sweep.sv
module rf_sweep
    import rf_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             frame_start,
    input  logic             vblank,
    input  logic [CNT_W-1:0] discard_lo,
    input  logic [CNT_W-1:0] discard_hi,
    input  logic [CNT_W-1:0] rd_cnt,
    output logic             accept,
    output logic             scanning,
    output logic [PIX_W-1:0] scan_idx,
    output logic [PIX_W-1:0] range_lo,
    output logic [PIX_W-1:0] range_hi
);
    localparam logic [PIX_W-1:0] VMAX = {PIX_W{1'b1}};

    typedef struct packed {
        sweep_phase_e     ph;
        logic             vb;
        logic [PIX_W-1:0] idx;
        logic [CNT_W-1:0] sum;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] target;
        logic             lo_found;
        logic             hi_found;
        logic [PIX_W-1:0] lo_c;
        logic [PIX_W-1:0] hi_c;
        logic [PIX_W-1:0] lo;
        logic [PIX_W-1:0] hi;
    } sweep_st_t;

    sweep_st_t s_q, s_d;
    logic [CNT_W-1:0] run_sum;

    assign accept = pix_valid && !vblank && (s_q.ph == PH_IDLE);

    always_comb begin
        s_d     = s_q;
        s_d.vb  = vblank;
        run_sum = s_q.sum + rd_cnt;
        if (s_q.ph == PH_IDLE) begin
            if (frame_start)  s_d.total = accept ? CNT_W'(1) : '0;
            else if (accept)  s_d.total = s_q.total + CNT_W'(1);
            if (vblank && !s_q.vb) begin
                s_d.ph       = PH_SCAN;
                s_d.idx      = '0;
                s_d.sum      = '0;
                s_d.lo_found = 1'b0;
                s_d.hi_found = 1'b0;
                s_d.target   = (s_q.total > discard_hi) ? s_q.total - discard_hi : '0;
            end
        end else begin
            s_d.sum = run_sum;
            if (!s_q.lo_found && run_sum > discard_lo) begin
                s_d.lo_found = 1'b1;
                s_d.lo_c     = s_q.idx;
            end
            if (!s_q.hi_found && run_sum >= s_q.target) begin
                s_d.hi_found = 1'b1;
                s_d.hi_c     = s_q.idx;
            end
            if (s_q.idx == VMAX) begin
                s_d.ph = PH_IDLE;
                s_d.lo = s_d.lo_found ? s_d.lo_c : VMAX;
                s_d.hi = s_d.hi_found ? s_d.hi_c : VMAX;
            end else begin
                s_d.idx = s_q.idx + PIX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
            s_q.lo <= '0;
            s_q.hi <= VMAX;
        end else begin
            s_q <= s_d;
        end
    end

    assign scanning = (s_q.ph == PH_SCAN);
    assign scan_idx = s_q.idx;
    assign range_lo = s_q.lo;
    assign range_hi = s_q.hi;

    // R3
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && s_q.idx != VMAX) |=> (scanning && s_q.idx == $past(s_q.idx) + PIX_W'(1)));

    // R3
    scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && s_q.idx == VMAX) |=> !scanning);

    // R9
    range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && s_q.idx != VMAX) |=> ($stable(range_lo) && $stable(range_hi)));

    // R9
    sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> (s_q.sum <= s_q.total));
endmodule

// File: rtl/rf_range_check.sv
module rf_range_check #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [PIX_W-1:0] pix_data,
    input  logic [PIX_W-1:0] range_lo,
    input  logic [PIX_W-1:0] range_hi,
    output logic             flag_valid,
    output logic             in_range
);
    typedef struct packed {
        logic vld;
        logic hit;
    } flag_st_t;

    flag_st_t f_q, f_d;

    always_comb begin
        f_d.vld = accept;
        f_d.hit = accept && (pix_data >= range_lo) && (pix_data <= range_hi);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flag_valid = f_q.vld;
    assign in_range   = f_q.hit;

    // R8
    flag_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_range |-> flag_valid);
endmodule

// File: rtl/pixel_range_finder.sv
module pixel_range_finder #(
    parameter int PIX_W = 8,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             frame_start,
    input  logic             vblank,
    input  logic [CNT_W-1:0] discard_lo,
    input  logic [CNT_W-1:0] discard_hi,
    output logic [PIX_W-1:0] range_lo,
    output logic [PIX_W-1:0] range_hi,
    output logic             flag_valid,
    output logic             in_range
);
    logic             accept;
    logic             scanning;
    logic [PIX_W-1:0] scan_idx;
    logic [CNT_W-1:0] rd_cnt;

    rf_sweep #(.PIX_W(PIX_W), .CNT_W(CNT_W)) sweep_i (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
        .frame_start(frame_start), .vblank(vblank),
        .discard_lo(discard_lo), .discard_hi(discard_hi),
        .rd_cnt(rd_cnt), .accept(accept), .scanning(scanning),
        .scan_idx(scan_idx), .range_lo(range_lo), .range_hi(range_hi)
    );

    rf_hist_bank #(.PIX_W(PIX_W), .CNT_W(CNT_W)) hist_i (
        .clk(clk), .rst_n(rst_n), .inc_en(accept), .inc_idx(pix_data),
        .clr_en(scanning), .rd_idx(scan_idx), .rd_cnt(rd_cnt)
    );

    rf_range_check #(.PIX_W(PIX_W)) check_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .pix_data(pix_data),
        .range_lo(range_lo), .range_hi(range_hi),
        .flag_valid(flag_valid), .in_range(in_range)
    );

    // R2
    no_flag_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank || scanning) |=> !flag_valid);
endmodule

// File: tb/pixel_range_finder_tb.sv
module pixel_range_finder_tb_top;
    localparam int PIX_W = 8;
    localparam int CNT_W = 20;
    localparam int NB    = 1 << PIX_W;
    localparam int VMAX  = NB - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             pix_valid;
    logic [PIX_W-1:0] pix_data;
    logic             frame_start;
    logic             vblank;
    logic [CNT_W-1:0] discard_lo;
    logic [CNT_W-1:0] discard_hi;
    logic [PIX_W-1:0] range_lo;
    logic [PIX_W-1:0] range_hi;
    logic             flag_valid;
    logic             in_range;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    int ref_hist [NB];
    int ref_total;
    int ref_lo;
    int ref_hi;

    always #2.5 clk = ~clk;

    pixel_range_finder #(.PIX_W(PIX_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
        .frame_start(frame_start), .vblank(vblank),
        .discard_lo(discard_lo), .discard_hi(discard_hi),
        .range_lo(range_lo), .range_hi(range_hi),
        .flag_valid(flag_valid), .in_range(in_range)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ref_bounds(int dlo, int dhi);
        int cum = 0;
        int tgt;
        bit flo = 0;
        bit fhi = 0;
        ref_lo = VMAX;
        ref_hi = VMAX;
        tgt = (ref_total > dhi) ? ref_total - dhi : 0;
        for (int v = 0; v < NB; v++) begin
            cum += ref_hist[v];
            if (!flo && cum > dlo) begin flo = 1; ref_lo = v; end
            if (!fhi && cum >= tgt) begin fhi = 1; ref_hi = v; end
        end
        for (int v = 0; v < NB; v++) ref_hist[v] = 0;
    endtask

    function automatic int pix_of(int kind, int i);
        case (kind)
            0: return 40 + (i * 7) % 150;
            1: return (i * i * 13 + i * 5) % NB;
            2: return (i * 29 + 3) % NB;
            3: return 128;
            default: return 120 + (i % 21);
        endcase
    endfunction

    task automatic run_frame(int n, int kind, int dlo, int dhi, bit gaps);
        int p;
        bit v;
        discard_lo = CNT_W'(dlo);
        discard_hi = CNT_W'(dhi);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            p = pix_of(kind, i);
            v = (kind != 9) && !(gaps && (i % 4 == 3));
            pix_valid   = v;
            pix_data    = PIX_W'(p);
            frame_start = (i == 0);
            @(posedge clk);
            #1;
            if (i == 0) ref_total = 0;
            if (v) begin
                ref_hist[p]++;
                ref_total++;
            end
            // R8: flag follows an accepted pixel one clock later, compared with the previous frame's bounds
            chk("R8 flag_valid", int'(flag_valid), int'(v));
            if (v) chk("R8 in_range", int'(in_range), int'(p >= ref_lo && p <= ref_hi));
            // R9: range registers stay put through the active frame
            chk("R9 range_lo", int'(range_lo), ref_lo);
            chk("R9 range_hi", int'(range_hi), ref_hi);
        end
        @(negedge clk);
        pix_valid   = 0;
        frame_start = 0;
    endtask

    task automatic run_blank(int dlo, int dhi);
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            vblank    = 1;
            // R2: junk valid pixels during the blank must be ignored
            pix_valid = (c % 3 == 0);
            pix_data  = (c % 2 == 0) ? PIX_W'(0) : PIX_W'(VMAX);
            @(posedge clk);
            #1;
            if (c > 0) chk("R2 no flag in blank", int'(flag_valid), 0);
        end
        @(negedge clk);
        vblank    = 0;
        pix_valid = 0;
        ref_bounds(dlo, dhi);
        @(posedge clk);
        #1;
        // R4, R5: bounds after the sweep (R3 loads them within the blank)
        chk("R4 range_lo", int'(range_lo), ref_lo);
        chk("R5 range_hi", int'(range_hi), ref_hi);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=0", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 0; pix_valid = 0; pix_data = '0; frame_start = 0; vblank = 0;
        discard_lo = '0; discard_hi = '0;
        for (int v = 0; v < NB; v++) ref_hist[v] = 0;
        ref_total = 0; ref_lo = 0; ref_hi = VMAX;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 range_lo", int'(range_lo), 0);
        chk("R1 range_hi", int'(range_hi), VMAX);
        chk("R1 flag_valid", int'(flag_valid), 0);

        // R1: first frame passes all; R4/R5 with small discards
        run_frame(200, 0, 3, 5, 0);
        run_blank(3, 5);
        // R6, R7: second frame from a cleared histogram, with gaps (R2)
        run_frame(300, 1, 10, 20, 1);
        run_blank(10, 20);
        // R4, R5: discard counts at or above the total
        run_frame(50, 2, 60, 100, 0);
        run_blank(60, 100);
        // empty frame: low search fails, high target is zero
        run_frame(1, 9, 0, 0, 0);
        run_blank(0, 0);
        // single repeated value, no discards
        run_frame(100, 3, 0, 0, 0);
        run_blank(0, 0);
        // probe the one-value window on both sides
        run_frame(60, 4, 0, 0, 0);
        run_blank(0, 0);
        chk("R4 single value lo", ref_lo, 120);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule